// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Multiprocessor Addressing

The block sends and receives characters on a pair of serial lines. The transmit and receive sides run on their own, and each side has a holding register in front of its shift register, so a new character can be queued while the current one is on the line. One configuration byte sets the character length (7 or 8 bits), the stop length (1 or 2 bits), the parity (none, even or odd), an optional address/data flag bit after the data and parity, and the bit order. A 16x oversampling tick comes either from an internal programmable divider or from an external clock pin.

The receiver finds a start bit by seeing the line low for half a bit, then takes each following bit at its centre. It records parity, framing and overrun errors as sticky flags, and the status word shows the synchronised receive line level, so software can tell a break (line held low) from a framing error. In multiprocessor mode the receiver can be told to wait for an address: until a frame with the flag bit set arrives, frames with the flag clear are dropped and leave no trace. A host reaches four byte registers through write and read strobes.

Top module: `async_xcvr`

## Requirements
- R1: After reset txd_o is 1, the configuration register (address 2) reads 0x00, the divider (address 3) reads 0x03 and the status (address 1) reads 0x50. Status bits: 7 address-wait, 6 receive line level, 5 last received flag bit, 4 transmit holding register empty, 3 receive data ready, 2 parity error, 1 framing error, 0 overrun.
- R2: A byte written to address 0 is sent as a start bit (0), the data bits least significant first (7 bits when config bit 0 is set, else 8), then stop bits (1); each bit lasts 16 ticks, and a tick comes every (divider + 1) clocks.
- R3: With config bit 2 set a parity bit follows the data; it makes the count of ones in data plus parity even, or odd when config bit 3 is set.
- R4: Config bit 1 selects two stop bits. With config bit 4 set a flag bit, taken from config bit 7, follows the data and parity.
- R5: Config bit 5 selects most-significant-first order for 8-bit characters on both directions; for 7-bit characters it has no effect.
- R6: While a character is being sent, a second queued byte starts with its start bit right after the last stop bit of the first, with no idle time; status bit 4 returns to 1 as soon as the queued byte moves into the shifter.
- R7: A received frame sets status bit 3 and its data reads at address 0; a read of address 0 clears bit 3. A parity mismatch sets bit 2. Errors stay set until any write to address 1, which also loads the address-wait bit from write data bit 7.
- R8: A stop bit read as 0 sets status bit 1, and status bit 6 follows the line level, so a line held low shows 0; the receiver does not start another frame until the line has been high.
- R9: A frame completing while status bit 3 is set sets status bit 0; the new character is dropped and the held one is kept.
- R10: With config bit 4 set and the address-wait bit set, frames whose flag bit is 0 are dropped with no flag change; a frame whose flag bit is 1 is accepted, sets status bit 5 and clears the address-wait bit.
- R11: With config bit 6 set each rising edge of ext_clk_i is one tick; otherwise the divider at address 3 sets the tick rate.
- R12: A low pulse on rxd_i shorter than half a bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (address 0 read takes the received byte) |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 config, 3 divider |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| ext_clk_i | input | 1 | External 16x bit clock |

## Verification
The transmit line is sampled at bit centres and compared with a frame built in the bench from the requirement text for plain 8-bit, 7-bit with even parity, 8-bit with odd parity, two stops and reversed order, and frames carrying a flag bit of either value, which separates mistakes in field order, parity sense and stop count. Two queued bytes are checked as one unbroken bit stream, and the same frame is timed from both the divider and the external pin. On the receive side, clean frames, a flipped parity bit, a zero stop followed by a held-low line, two frames without a read, address-wait filtering with both flag values, and a short low glitch each isolate one flag or one dropping rule.

// File: rtl/axcvr_pkg.sv
package axcvr_pkg;
  localparam int FRAME_W = 13;  // start + 8 data + parity + flag + 2 stop
  localparam int RXB_W   = 11;  // sampled bits after start: 8 + parity + flag + stop
  localparam int OVS_W   = 4;   // 16x oversampling counter
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef struct packed {
    logic tx_flag;
    logic ext_clk;
    logic msb_first;
    logic mp_en;
    logic par_odd;
    logic par_en;
    logic stop2;
    logic len7;
  } cfg_t;
endpackage

// File: rtl/axcvr_baud.sv
module axcvr_baud #(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;
  logic [SYNC_N:0]  es;
  logic             int_tick;

  assign int_tick = (cnt >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      es  <= '0;
    end else begin
      cnt <= int_tick ? '0 : cnt + 1'b1;
      es  <= {es[SYNC_N-1:0], ext_clk_i};
    end
  end

  assign tick_o = ext_sel_i ? (es[SYNC_N-1] & ~es[SYNC_N]) : int_tick;
endmodule

// File: rtl/axcvr_tx.sv
module axcvr_tx
  import axcvr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       len7_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mp_en_i,
  input  logic       flag_i,
  input  logic       msb_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       take_o,
  output logic       busy_o,
  output logic       txd_o
);
  logic [FRAME_W-1:0] fr, sh;
  logic [3:0]         len, left;
  logic [OVS_W-1:0]   tcnt;
  logic               busy, fin, dpar;

  always_comb begin
    int k;
    fr    = '1;
    fr[0] = 1'b0;
    k     = 1;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || !len7_i) begin
        fr[k] = msb_i ? data_i[7-i] : data_i[i];
        k++;
      end
    end
    dpar = ^(len7_i ? {1'b0, data_i[6:0]} : data_i);
    if (par_en_i) begin
      fr[k] = dpar ^ par_odd_i;
      k++;
    end
    if (mp_en_i) begin
      fr[k] = flag_i;
      k++;
    end
    k   = k + (stop2_i ? 2 : 1);
    len = 4'(k);
  end

  assign fin    = busy & tick_i & (&tcnt) & (left == 4'd1);
  assign take_o = load_i & (~busy | fin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (take_o) begin
      sh   <= fr;
      left <= len;
      tcnt <= '0;
      busy <= 1'b1;
    end else if (fin) begin
      busy <= 1'b0;
      sh   <= '1;
    end else if (busy && tick_i) begin
      tcnt <= tcnt + 1'b1;
      if (&tcnt) begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  assign busy_o = busy;
  assign txd_o  = sh[0];
endmodule

// File: rtl/axcvr_rx.sv
module axcvr_rx
  import axcvr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       len7_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       mp_en_i,
  input  logic       msb_i,
  input  logic       rxd_i,
  output logic       line_o,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       flag_o
);
  logic [1:0]       rs;
  logic [RXB_W-1:0] bits;
  logic [OVS_W-1:0] cnt;
  logic [3:0]       idx, nd, mi, si;
  logic             active, armed, done_q, line;

  assign line = rs[1];
  assign nd   = len7_i ? 4'd7 : 4'd8;
  assign mi   = nd + {3'b0, par_en_i};
  assign si   = mi + {3'b0, mp_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs     <= 2'b11;
      bits   <= '0;
      cnt    <= '0;
      idx    <= '0;
      active <= 1'b0;
      armed  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rs     <= {rs[0], rxd_i};
      done_q <= 1'b0;
      if (tick_i) begin
        if (!active) begin
          if (line) begin
            armed <= 1'b1;
            cnt   <= '0;
          end else if (armed) begin
            if (cnt == 4'd7) begin  // half a bit low: start confirmed
              active <= 1'b1;
              cnt    <= '0;
              idx    <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (&cnt) begin
            bits[idx] <= line;
            if (idx == si) begin
              active <= 1'b0;
              armed  <= 1'b0;
              done_q <= 1'b1;
            end else idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++)
      data_o[i] = msb_i ? bits[7-i] : ((4'(i) < nd) ? bits[i] : 1'b0);
  end

  assign perr_o = par_en_i & (bits[nd] != (^data_o ^ par_odd_i));
  assign flag_o = mp_en_i & bits[mi];
  assign ferr_o = ~bits[si];
  assign done_o = done_q;
  assign line_o = line;
endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
  import axcvr_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  input  logic       ext_clk_i
);
  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       hold_q, rx_data_q, rx_data;
  logic             hold_full, rx_full, oerr_q, ferr_q, perr_q, flag_q, wait_q;
  logic             tick, tx_take, tx_busy, msb_eff;
  logic             rx_line, rx_done, rx_perr, rx_ferr, rx_flag, discard;

  assign msb_eff = cfg_q.msb_first & ~cfg_q.len7;
  assign discard = cfg_q.mp_en & wait_q & ~rx_flag;

  axcvr_baud #(.DIV_W(DIV_W), .SYNC_N(2)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q), .ext_sel_i(cfg_q.ext_clk),
    .ext_clk_i, .tick_o(tick)
  );

  axcvr_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .len7_i(cfg_q.len7), .stop2_i(cfg_q.stop2),
    .par_en_i(cfg_q.par_en), .par_odd_i(cfg_q.par_odd), .mp_en_i(cfg_q.mp_en),
    .flag_i(cfg_q.tx_flag), .msb_i(msb_eff), .load_i(hold_full), .data_i(hold_q),
    .take_o(tx_take), .busy_o(tx_busy), .txd_o
  );

  axcvr_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .len7_i(cfg_q.len7), .par_en_i(cfg_q.par_en),
    .par_odd_i(cfg_q.par_odd), .mp_en_i(cfg_q.mp_en), .msb_i(msb_eff), .rxd_i,
    .line_o(rx_line), .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr),
    .ferr_o(rx_ferr), .flag_o(rx_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      div_q     <= DIV_W'(DIV_RST);
      hold_q    <= '0;
      hold_full <= 1'b0;
      rx_data_q <= '0;
      rx_full   <= 1'b0;
      oerr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
      flag_q    <= 1'b0;
      wait_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          A_DATA: if (!hold_full) begin
            hold_q    <= wdata_i;
            hold_full <= 1'b1;
          end
          A_CFG:   cfg_q <= cfg_t'(wdata_i);
          A_DIV:   div_q <= DIV_W'(wdata_i);
          default: ;
        endcase
      end
      if (tx_take) hold_full <= 1'b0;
      if (rd_i && addr_i == A_DATA) rx_full <= 1'b0;
      if (rx_done && !discard) begin
        if (rx_full) oerr_q <= 1'b1;  // keep held byte, drop new one
        else begin
          rx_data_q <= rx_data;
          rx_full   <= 1'b1;
          perr_q    <= perr_q | rx_perr;
          ferr_q    <= ferr_q | rx_ferr;
          flag_q    <= rx_flag;
          if (rx_flag) wait_q <= 1'b0;
        end
      end
      if (wr_i && addr_i == A_STAT) begin
        oerr_q <= 1'b0;
        ferr_q <= 1'b0;
        perr_q <= 1'b0;
        wait_q <= wdata_i[7];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_DATA:  rdata_o = rx_data_q;
      A_STAT:  rdata_o = {wait_q, rx_line, flag_q, ~hold_full, rx_full, perr_q, ferr_q, oerr_q};
      A_CFG:   rdata_o = cfg_q;
      default: rdata_o = 8'(div_q);
    endcase
  end
endmodule

// File: rtl/async_xcvr_chk.sv
module async_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       txd_o,
  input logic       tx_take,
  input logic       hold_full,
  input logic       rx_done,
  input logic       rx_ferr,
  input logic       rx_flag,
  input logic       mp_en,
  input logic       wait_q,
  input logic       rx_full,
  input logic       oerr_q,
  input logic       ferr_q,
  input logic       perr_q,
  input logic [7:0] rx_data_q
);
  p_take_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |=> !hold_full);

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |=> !txd_o);

  p_overrun_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_full && !(mp_en && wait_q && !rx_flag) && !wr_i) |=> (oerr_q && $stable(rx_data_q)));

  p_discard_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && mp_en && wait_q && !rx_flag && !wr_i) |=> ($stable({oerr_q, ferr_q, perr_q}) && wait_q));

  p_stop_error_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_ferr && !rx_full && !(mp_en && wait_q && !rx_flag) && !wr_i) |=> ferr_q);
endmodule

bind async_xcvr async_xcvr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .txd_o(txd_o), .tx_take(tx_take),
  .hold_full(hold_full), .rx_done(rx_done), .rx_ferr(rx_ferr), .rx_flag(rx_flag),
  .mp_en(cfg_q.mp_en), .wait_q(wait_q), .rx_full(rx_full), .oerr_q(oerr_q),
  .ferr_q(ferr_q), .perr_q(perr_q), .rx_data_q(rx_data_q)
);

// File: tb/async_xcvr_test.sv
`timescale 1ns/1ps
module async_xcvr_test;
  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, rxd = 1'b1, ext_clk = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       txd;
  int tests = 0, fails = 0;

  async_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .ext_clk_i(ext_clk)
  );

  always #5 clk = ~clk;
  initial forever #40 ext_clk = ~ext_clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // Reference frame built from the requirement text
  function automatic void build(input logic [7:0] cfg, input logic [7:0] d, input logic fl,
                                output logic [15:0] f, output int n);
    int nd = cfg[0] ? 7 : 8;
    logic msb = cfg[5] && !cfg[0];
    logic [7:0] dm = cfg[0] ? {1'b0, d[6:0]} : d;
    int ones = 0;
    f = '1; f[0] = 1'b0; n = 1;
    for (int i = 0; i < nd; i++) begin
      f[n] = msb ? dm[nd-1-i] : dm[i];
      ones += int'(dm[i]);
      n++;
    end
    if (cfg[2]) begin f[n] = (ones % 2 == 1) ^ cfg[3]; n++; end
    if (cfg[4]) begin f[n] = fl; n++; end
    f[n] = 1'b1; n++;
    if (cfg[1]) begin f[n] = 1'b1; n++; end
  endfunction

  task automatic tx_grab(input int n, input int bc, input bit contig, output logic [15:0] got);
    got = '1;
    if (!contig) begin
      while (txd !== 1'b0) @(negedge clk);
      repeat (bc/2) @(negedge clk);
    end else repeat (bc) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (bc) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic tx_case(input string tag, input logic [7:0] cfg, input logic [7:0] d, input int bc);
    logic [15:0] f, got, m;
    int n;
    wr_reg(2, cfg);
    wr_reg(0, d);
    build(cfg, d, cfg[7], f, n);
    tx_grab(n, bc, 1'b0, got);
    m = 16'((1 << n) - 1);
    chk(tag, got & m, f & m);
    repeat (bc) @(negedge clk);
  endtask

  task automatic rx_send(input logic [15:0] f, input int n, input bit hold_low);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (63) @(negedge clk);
    end
    if (!hold_low) begin
      @(negedge clk); rxd = 1'b1;
      repeat (40) @(negedge clk);
    end
  endtask

  task automatic rx_frame(input logic [7:0] cfg, input logic [7:0] d, input logic fl);
    logic [15:0] f;
    int n;
    build(cfg, d, fl, f, n);
    rx_send(f, n, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] f1, f2, g1, g2;
    int n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 txd", {15'b0, txd}, 16'h1);
    rd_reg(1, v); chk("R1 status", {8'b0, v}, 16'h50);
    rd_reg(2, v); chk("R1 cfg", {8'b0, v}, 16'h00);
    rd_reg(3, v); chk("R1 div", {8'b0, v}, 16'h03);

    tx_case("R2 8N1", 8'h00, 8'hA5, 64);
    tx_case("R2 7N1", 8'h01, 8'h4C, 64);
    tx_case("R3 7E1", 8'h05, 8'h5B, 64);
    tx_case("R3 8O1", 8'h0C, 8'h5B, 64);
    tx_case("R4 8O2 msb", 8'h2E, 8'h31, 64);
    tx_case("R4 flag1", 8'h90, 8'h42, 64);
    tx_case("R4 flag0", 8'h10, 8'h42, 64);
    tx_case("R5 msb8", 8'h20, 8'hC4, 64);
    tx_case("R5 msb7 ignored", 8'h21, 8'h36, 64);

    // R6: two queued bytes run back to back
    wr_reg(2, 8'h00);
    wr_reg(0, 8'h11);
    wr_reg(0, 8'h2E);
    rd_reg(1, v); chk("R6 hold empty", {15'b0, v[4]}, 16'h0);
    build(8'h00, 8'h11, 1'b0, f1, n1);
    build(8'h00, 8'h2E, 1'b0, f2, n2);
    tx_grab(n1, 64, 1'b0, g1);
    tx_grab(n2, 64, 1'b1, g2);
    chk("R6 first", g1 & 16'h3FF, f1 & 16'h3FF);
    chk("R6 second", g2 & 16'h3FF, f2 & 16'h3FF);
    rd_reg(1, v); chk("R6 empty again", {15'b0, v[4]}, 16'h1);
    repeat (64) @(negedge clk);

    // R11: external clock and divider change
    tx_case("R11 ext", 8'h40, 8'h96, 128);
    wr_reg(3, 8'h07);
    tx_case("R11 div7", 8'h00, 8'h0F, 128);
    wr_reg(3, 8'h03);
    wr_reg(2, 8'h00);

    // R7: receive, read clears ready
    rx_frame(8'h00, 8'h3C, 1'b0);
    rd_reg(1, v); chk("R7 ready", {8'b0, v}, 16'h58);
    rd_reg(0, v); chk("R7 data", {8'b0, v}, 16'h3C);
    rd_reg(1, v); chk("R7 cleared", {8'b0, v}, 16'h50);

    // R7: parity error
    wr_reg(2, 8'h05);
    build(8'h05, 8'h5B, 1'b0, f1, n1);
    f1[8] = ~f1[8];
    rx_send(f1, n1, 1'b0);
    rd_reg(1, v); chk("R7 perr", {8'b0, v}, 16'h5C);
    rd_reg(0, v); chk("R7 perr data", {8'b0, v}, 16'h5B);
    wr_reg(1, 8'h00);
    rd_reg(1, v); chk("R7 err clear", {8'b0, v}, 16'h50);

    // R8: stop bit low then line held low
    wr_reg(2, 8'h00);
    build(8'h00, 8'h7E, 1'b0, f1, n1);
    f1[9] = 1'b0;
    rx_send(f1, n1, 1'b1);
    repeat (200) @(negedge clk);
    rd_reg(1, v); chk("R8 ferr line low", {8'b0, v}, 16'h1A);
    rd_reg(0, v); chk("R8 data", {8'b0, v}, 16'h7E);
    rxd = 1'b1;
    repeat (800) @(negedge clk);
    rd_reg(1, v); chk("R8 no restart", {8'b0, v}, 16'h52);
    wr_reg(1, 8'h00);

    // R9: overrun keeps first byte
    rx_frame(8'h00, 8'hA1, 1'b0);
    rx_frame(8'h00, 8'hB2, 1'b0);
    rd_reg(1, v); chk("R9 oerr", {8'b0, v}, 16'h59);
    rd_reg(0, v); chk("R9 kept", {8'b0, v}, 16'hA1);
    wr_reg(1, 8'h00);

    // R5: receive most significant first
    wr_reg(2, 8'h20);
    rx_frame(8'h20, 8'h12, 1'b0);
    rd_reg(0, v); chk("R5 rx msb", {8'b0, v}, 16'h12);

    // R10: address wait filtering
    wr_reg(2, 8'h10);
    wr_reg(1, 8'h80);
    rd_reg(1, v); chk("R10 wait set", {8'b0, v}, 16'hD0);
    rx_frame(8'h10, 8'h11, 1'b0);
    rd_reg(1, v); chk("R10 dropped", {8'b0, v}, 16'hD0);
    rx_frame(8'h10, 8'h22, 1'b1);
    rd_reg(1, v); chk("R10 addr taken", {8'b0, v}, 16'h78);
    rd_reg(0, v); chk("R10 addr data", {8'b0, v}, 16'h22);
    rx_frame(8'h10, 8'h33, 1'b0);
    rd_reg(1, v); chk("R10 data after", {8'b0, v}, 16'h58);
    rd_reg(0, v); chk("R10 data byte", {8'b0, v}, 16'h33);

    // R12: short glitch ignored
    wr_reg(2, 8'h00);
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (1300) @(negedge clk);
    rd_reg(1, v); chk("R12 glitch", {8'b0, v}, 16'h50);
    rx_frame(8'h00, 8'h5A, 1'b0);
    rd_reg(0, v); chk("R12 next frame", {8'b0, v}, 16'h5A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule